// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit charge-balancing successive-approximation converter. It steps a fixed frame of 15 clock periods. Periods 1 to 3 acquire the input: the capacitor array is switched to the input and the comparator auto-zero is on. Periods 4 to 15 resolve one result bit each, from the most significant bit down. On the edge that ends period 15, the finished code goes into an output register, and the frame starts over at period 1.

The block drives the track switch, the comparator auto-zero enable and the 12-bit trial vector that sets the capacitor array. It samples the 1-bit comparator decision on every edge during a bit trial. A data-ready flag marks each new result. The active-low start input picks the run mode:
- Held low, the block converts back to back, one result every 15 cycles.
- Seen high at the end of period 1, the block parks in period 2 and keeps tracking. It resumes when start goes low again.

Two active-low enables gate the upper eight and the lower four output bits separately.

Top module: `sar_cycle_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in period 1, clears the output register and drives data-ready low. While reset is held, track and auto-zero are high and the trial vector is zero.
- R2: In periods 1 to 3, track_en and autozero_en are high and trial_code is zero. In periods 4 to 15 both enables are low.
- R3: In period 4, trial_code has only bit 11 set (0x800).
- R4: In period p, for p from 4 to 15, trial_code holds the bits already decided above bit (15-p), with bit (15-p) set and every lower bit clear. On the edge that ends the period, cmp_in high keeps that bit and cmp_in low clears it. cmp_in high means the input is at or above the trial level.
- R5: The result is straight binary. An input equal to code 0 yields 0, full scale yields 4095, mid-scale yields 2048, and every code yields itself when the comparator is ideal.
- R6: The output register loads only on the edge that enters period 1. It holds its value through every other period of the next frame, including a parked period 2.
- R7: data_ready rises on the edge that enters period 1. It falls on the edge that enters period 2 when start_n is low at the end of period 1.
- R8: If start_n is high at the end of period 1, the sequencer parks in period 2, tracking, with data_ready and the result unchanged. On the first edge that samples start_n low, it moves to period 3 and drops data_ready. The new result appears 13 edges after that.
- R9: With start_n held low, conversions run back to back, one new result every 15 clock cycles.
- R10: oe_hi_n low enables output bits 11..4 and oe_lo_n low enables bits 3..0. An enabled bit has dout_en set and dout equal to the stored bit. A disabled bit has dout_en clear and dout zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Conversion start, active low; held low gives free-running mode |
| cmp_in | input | 1 | Comparator decision; high keeps the bit under trial |
| oe_hi_n | input | 1 | Active-low output enable for bits 11..4 |
| oe_lo_n | input | 1 | Active-low output enable for bits 3..0 |
| track_en | output | 1 | Capacitor array switched to the analog input |
| autozero_en | output | 1 | Comparator auto-balance enable |
| trial_code | output | 12 | Trial vector driving the capacitor array during bit trials |
| data_ready | output | 1 | New-result flag |
| dout | output | 12 | Result bits, zero where not enabled |
| dout_en | output | 12 | Per-bit drive enable; clear means high impedance |

## Verification
The bench walks every period of one frame and compares the trial vector with the value an ideal comparator implies. A frame that is off by one period would show the MSB probe in the wrong cycle or lose the LSB. It checks the output register in period 15 of the following frame, which catches a design that publishes the result early or lets it follow the working register. It parks the sequencer in period 2 for many cycles and then releases it. A design that keeps counting, or drops data-ready early, or resumes at the wrong period, returns a wrong code or the wrong timing. Reset in mid-frame and every combination of the two output enables are also covered.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned SAR_BITS_DEF  = 12;
    localparam int unsigned TRACK_LEN_DEF = 3;
    localparam int unsigned HI_GROUP_DEF  = 8;
    localparam int unsigned PARK_PERIOD   = 2;

    typedef enum logic {
        RUN_FREE   = 1'b0,
        RUN_PARKED = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic track;
        logic trial;
        logic last;
    } seq_step_s;

    function automatic int unsigned frame_len(int unsigned bits, int unsigned trk);
        return bits + trk;
    endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned SAR_BITS  = SAR_BITS_DEF,
    parameter int unsigned TRACK_LEN = TRACK_LEN_DEF,
    localparam int unsigned FRAME = frame_len(SAR_BITS, TRACK_LEN),
    localparam int unsigned PW    = $clog2(FRAME + 1),
    localparam int unsigned IW    = $clog2(SAR_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_n,
    output logic [PW-1:0] period,
    output seq_step_s     step,
    output logic [IW-1:0] bit_idx,
    output logic          data_ready
);

    localparam logic [PW-1:0] P_FIRST = PW'(1);
    localparam logic [PW-1:0] P_PARK  = PW'(PARK_PERIOD);
    localparam logic [PW-1:0] P_TRKND = PW'(TRACK_LEN);
    localparam logic [PW-1:0] P_FRAME = PW'(FRAME);

    run_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            period     <= P_FIRST;
            mode       <= RUN_FREE;
            data_ready <= 1'b0;
        end else if (period == P_FRAME) begin
            period     <= P_FIRST;
            data_ready <= 1'b1;
        end else if (period == P_FIRST) begin
            period <= P_PARK;
            if (start_n) begin
                mode <= RUN_PARKED;
            end else begin
                data_ready <= 1'b0;
            end
        end else if (period == P_PARK && mode == RUN_PARKED) begin
            if (!start_n) begin
                period     <= period + PW'(1);
                mode       <= RUN_FREE;
                data_ready <= 1'b0;
            end
        end else begin
            period <= period + PW'(1);
        end
    end

    always_comb begin
        step.track = (period <= P_TRKND);
        step.trial = !step.track;
        step.last  = (period == P_FRAME);
        bit_idx    = step.trial ? IW'(P_FRAME - period) : '0;
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (period == P_FRAME) |=> (period == P_FIRST && data_ready)); // R7

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (period == P_FIRST && !start_n) |=> !data_ready); // R7

    AST_PARK_STAY: assert property (@(posedge clk) disable iff (rst)
        (period == P_PARK && mode == RUN_PARKED && start_n)
        |=> (period == P_PARK && $stable(data_ready))); // R8

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned SAR_BITS = SAR_BITS_DEF,
    localparam int unsigned IW = $clog2(SAR_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  seq_step_s           step,
    input  logic [IW-1:0]       bit_idx,
    input  logic                cmp_in,
    output logic [SAR_BITS-1:0] trial_code,
    output logic [SAR_BITS-1:0] resolved
);

    logic [SAR_BITS-1:0] decided;
    logic [SAR_BITS-1:0] under_test;

    for (genvar k = 0; k < SAR_BITS; k++) begin : g_bit
        assign under_test[k] = step.trial && (bit_idx == IW'(k));
        assign trial_code[k] = decided[k] | under_test[k];
        assign resolved[k]   = decided[k] | (under_test[k] & cmp_in);
    end

    always_ff @(posedge clk) begin
        if (rst || step.last) begin
            decided <= '0;
        end else if (step.trial) begin
            decided <= resolved;
        end
    end

    AST_TRACK_NO_PROBE: assert property (@(posedge clk) disable iff (rst)
        step.track |-> (trial_code == '0)); // R2

    AST_TRIAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        step.last |=> (trial_code == '0)); // R4

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
    import sar_seq_pkg::*;
#(
    parameter int unsigned SAR_BITS = SAR_BITS_DEF,
    parameter int unsigned HI_GROUP = HI_GROUP_DEF,
    localparam int unsigned LO_GROUP = SAR_BITS - HI_GROUP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAR_BITS-1:0] result,
    input  logic                oe_hi_n,
    input  logic                oe_lo_n,
    output logic [SAR_BITS-1:0] dout,
    output logic [SAR_BITS-1:0] dout_en
);

    logic [SAR_BITS-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (load) begin
            out_q <= result;
        end
    end

    for (genvar k = 0; k < SAR_BITS; k++) begin : g_drv
        if (k >= LO_GROUP) begin : g_hi
            assign dout_en[k] = !oe_hi_n;
        end else begin : g_lo
            assign dout_en[k] = !oe_lo_n;
        end
        assign dout[k] = out_q[k] & dout_en[k];
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(out_q)); // R6

endmodule

// File: rtl/sar_cycle_sequencer.sv
module sar_cycle_sequencer
    import sar_seq_pkg::*;
#(
    parameter int unsigned SAR_BITS  = SAR_BITS_DEF,
    parameter int unsigned TRACK_LEN = TRACK_LEN_DEF,
    parameter int unsigned HI_GROUP  = HI_GROUP_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_n,
    input  logic                cmp_in,
    input  logic                oe_hi_n,
    input  logic                oe_lo_n,
    output logic                track_en,
    output logic                autozero_en,
    output logic [SAR_BITS-1:0] trial_code,
    output logic                data_ready,
    output logic [SAR_BITS-1:0] dout,
    output logic [SAR_BITS-1:0] dout_en
);

    localparam int unsigned FRAME = frame_len(SAR_BITS, TRACK_LEN);
    localparam int unsigned PW    = $clog2(FRAME + 1);
    localparam int unsigned IW    = $clog2(SAR_BITS);

    logic [PW-1:0]       period;
    seq_step_s           step;
    logic [IW-1:0]       bit_idx;
    logic [SAR_BITS-1:0] resolved;

    sar_phase_ctrl #(
        .SAR_BITS (SAR_BITS),
        .TRACK_LEN(TRACK_LEN)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .start_n   (start_n),
        .period    (period),
        .step      (step),
        .bit_idx   (bit_idx),
        .data_ready(data_ready)
    );

    sar_trial_reg #(
        .SAR_BITS(SAR_BITS)
    ) u_trial (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .bit_idx   (bit_idx),
        .cmp_in    (cmp_in),
        .trial_code(trial_code),
        .resolved  (resolved)
    );

    sar_out_stage #(
        .SAR_BITS(SAR_BITS),
        .HI_GROUP(HI_GROUP)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .load   (step.last),
        .result (resolved),
        .oe_hi_n(oe_hi_n),
        .oe_lo_n(oe_lo_n),
        .dout   (dout),
        .dout_en(dout_en)
    );

    assign track_en    = step.track;
    assign autozero_en = step.track;

    AST_PROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (period == PW'(1)) |-> (trial_code == '0 && track_en)); // R2

endmodule

// File: tb/sar_cycle_sequencer_tb.sv
module sar_cycle_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_n;
    logic        cmp_in;
    logic        oe_hi_n;
    logic        oe_lo_n;
    logic        track_en;
    logic        autozero_en;
    logic [11:0] trial_code;
    logic        data_ready;
    logic [11:0] dout;
    logic [11:0] dout_en;
    logic [11:0] vin_code;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    // ideal comparator: input at or above trial level keeps the bit
    assign cmp_in = (vin_code >= trial_code);

    sar_cycle_sequencer u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .cmp_in     (cmp_in),
        .oe_hi_n    (oe_hi_n),
        .oe_lo_n    (oe_lo_n),
        .track_en   (track_en),
        .autozero_en(autozero_en),
        .trial_code (trial_code),
        .data_ready (data_ready),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    localparam int NCODES = 10;
    localparam logic [11:0] CODES [NCODES] = '{
        12'h000, 12'hFFF, 12'h800, 12'h400, 12'hC00,
        12'h001, 12'hFFE, 12'hA5C, 12'h7FF, 12'h2B6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] exp_trial(input logic [11:0] code, input int p);
        int idx = 15 - p;
        logic [11:0] upper = 12'(32'hFFF << (idx + 1));
        return (code & upper) | 12'(1 << idx);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] prev;
        rst      = 1'b1;
        start_n  = 1'b0;
        oe_hi_n  = 1'b0;
        oe_lo_n  = 1'b0;
        vin_code = 12'h000;
        step(3);

        // R1 reset state
        chk("R1 ready", 32'(data_ready), 0);
        chk("R1 dout", 32'(dout), 0);
        chk("R1 track", 32'(track_en), 1);
        chk("R1 trial", 32'(trial_code), 0);

        rst      = 1'b0;
        vin_code = 12'h5A3;
        step(1);
        chk("R2 track p2", 32'({track_en, autozero_en}), 3);
        chk("R7 ready p2", 32'(data_ready), 0);
        step(1);
        chk("R2 track p3", 32'({track_en, autozero_en}), 3);
        chk("R2 trial p3", 32'(trial_code), 0);
        for (int p = 4; p <= 15; p++) begin
            step(1);
            chk("R2 no track", 32'({track_en, autozero_en}), 0);
            if (p == 4) chk("R3 msb probe", 32'(trial_code), 32'h800);
            else        chk("R4 trial", 32'(trial_code), 32'(exp_trial(12'h5A3, p)));
        end
        chk("R6 not yet", 32'(dout), 0);
        step(1);
        chk("R5 first result", 32'(dout), 32'h5A3);
        chk("R7 ready rise", 32'(data_ready), 1);

        // R9 back-to-back table
        prev = 12'h5A3;
        for (int i = 0; i < NCODES; i++) begin
            vin_code = CODES[i];
            step(1);
            chk("R7 ready fall", 32'(data_ready), 0);
            step(13);
            chk("R6 hold p15", 32'(dout), 32'(prev));
            step(1);
            chk("R5 R9 result", 32'(dout), 32'(CODES[i]));
            chk("R9 ready", 32'(data_ready), 1);
            prev = CODES[i];
        end

        // R10 enables (last code 0x2B6)
        oe_hi_n = 1'b1; oe_lo_n = 1'b0; #1;
        chk("R10 lo en", 32'(dout_en), 32'h00F);
        chk("R10 lo data", 32'(dout), 32'h006);
        oe_hi_n = 1'b0; oe_lo_n = 1'b1; #1;
        chk("R10 hi en", 32'(dout_en), 32'hFF0);
        chk("R10 hi data", 32'(dout), 32'h2B0);
        oe_hi_n = 1'b1; oe_lo_n = 1'b1; #1;
        chk("R10 none", 32'({dout_en, dout}), 0);
        oe_hi_n = 1'b0; oe_lo_n = 1'b0; #1;
        chk("R10 both", 32'(dout), 32'h2B6);

        // R8 single shot: park in period 2
        start_n  = 1'b1;
        vin_code = 12'h3C7;
        step(1);
        step(20);
        chk("R8 park ready", 32'(data_ready), 1);
        chk("R8 park track", 32'(track_en), 1);
        chk("R8 park dout", 32'(dout), 32'h2B6);
        start_n = 1'b0;
        step(1);
        chk("R8 resume ready", 32'(data_ready), 0);
        chk("R8 resume p3", 32'(track_en), 1);
        start_n = 1'b1;
        step(1);
        chk("R8 p4 probe", 32'({track_en, trial_code}), 32'h800);
        step(11);
        chk("R8 hold old", 32'(dout), 32'h2B6);
        step(1);
        chk("R8 result", 32'(dout), 32'h3C7);
        chk("R8 ready", 32'(data_ready), 1);
        step(6);
        chk("R8 reparked ready", 32'(data_ready), 1);
        chk("R8 reparked dout", 32'(dout), 32'h3C7);
        start_n = 1'b0;
        step(1);

        // R1 reset mid-frame
        step(5);
        rst = 1'b1;
        step(1);
        chk("R1 mid ready", 32'(data_ready), 0);
        chk("R1 mid dout", 32'(dout), 0);
        chk("R1 mid track", 32'({track_en, trial_code}), 32'h1000);
        rst      = 1'b0;
        vin_code = 12'hFFF;
        step(15);
        chk("R5 after reset", 32'(dout), 32'hFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule